// File: doc/BRIEF.md
# Interrupt Source State Controller

This block holds the per-source state of an interrupt source layer. Each of `NUM_SRC` inputs is fixed at build time as level-sensitive or message-type. Each source keeps a destination server, a live priority, a saved priority and four private flags: asserted, sent, rejected and masked-pending. Line changes, configuration requests and the presentation layer's reject, end-of-interrupt and resend requests drive these flags. The flags decide when a source is offered on a single forward channel as a source number, server and priority.

Source numbers are global. Source `i` has number `SRC_BASE + i`. Configuration requests take one cycle and return a status of 0 or -3 together with a readback. A resend request starts a scan that visits one source per clock. The scan pauses while the forward channel holds an offer that has not been accepted.

Top module: `irq_src_ctl`

## Requirements
- R1: After reset every source has server 0, live and saved priority 0xff, and all flags clear. No forward is offered and no scan is running.
- R2: A level source sets its asserted flag to the new line value whenever its line changes. If the source is then asserted, not sent and its priority is not 0xff, it sets sent and raises a forward request.
- R3: A message source reacts only to a rising edge of its line. With priority 0xff it sets masked-pending and raises no request. Otherwise it raises a forward request. A line held high or falling raises nothing.
- R4: A reject naming a source sets that source's rejected flag and clears its sent flag. It raises no request by itself.
- R5: A pulse on `resend_i` while idle starts a scan of sources 0 to NUM_SRC-1, one per clock, with `resend_busy_o` high until the scan is done. A message source with rejected set clears the flag and requests a forward if its priority is not 0xff. A level source applies its R2 rule.
- R6: An end-of-interrupt clears the sent flag of a level source. It has no effect on a message source, and it raises no request.
- R7: Op code 0 (set) writes the server, the priority and the saved priority. After any write, a level source re-applies its R2 rule. A message source with masked-pending and a priority other than 0xff clears the flag and requests a forward. If a write sets the priority to 0xff while a request is still unaccepted, the request is withdrawn: a message source sets masked-pending instead, and a level source clears sent.
- R8: Op code 1 (off) writes priority 0xff and saves the previous live priority, so a second off saves 0xff. Op code 2 (on) restores the live priority from the saved one. Both keep the server and then follow R7.
- R9: One cycle after `cfg_valid_i`, `cfg_done_o` pulses with status 0x00 on success or 0xFD (-3) on failure. The request fails, and changes nothing, if the number is outside `SRC_BASE .. SRC_BASE+NUM_SRC-1`, or if a set names a server of at least NUM_SERVERS or a priority above 0xff. Op code 3 (get) returns the server and live priority on the readback outputs.
- R10: The forward channel offers the lowest-indexed requesting source as number `SRC_BASE+i`, with that source's server and priority. The offer is held while `fwd_ready_i` is low, and the request clears when it is accepted.
- R11: While an offer waits unaccepted, the resend scan does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_line_i | input | NUM_SRC | Interrupt input lines |
| cfg_valid_i | input | 1 | Configuration request strobe |
| cfg_op_i | input | 2 | 0 set, 1 off, 2 on, 3 get |
| cfg_num_i | input | 16 | Global source number |
| cfg_server_i | input | 16 | Server for set |
| cfg_prio_i | input | 16 | Priority for set (valid up to 0xff) |
| cfg_done_o | output | 1 | Response strobe, one cycle after request |
| cfg_status_o | output | 8 | 0x00 success, 0xFD failure |
| cfg_rd_server_o | output | SRV_W | Server of addressed source |
| cfg_rd_prio_o | output | 8 | Live priority of addressed source |
| rej_valid_i | input | 1 | Reject strobe |
| rej_num_i | input | 16 | Rejected source number |
| eoi_valid_i | input | 1 | End-of-interrupt strobe |
| eoi_num_i | input | 16 | End-of-interrupt source number |
| resend_i | input | 1 | Start a resend scan |
| resend_busy_o | output | 1 | Scan in progress |
| fwd_valid_o | output | 1 | Forward offer valid |
| fwd_ready_i | input | 1 | Presentation layer accepts offer |
| fwd_num_o | output | 16 | Offered source number |
| fwd_server_o | output | SRV_W | Offered server |
| fwd_prio_o | output | 8 | Offered priority |

## Verification
The flags can only be seen through the forwards that follow. A wrong flag shows up as a missing, extra or repeated offer on the next line edge, configuration write or resend scan. Each flag transition is therefore followed by the one event that should or should not forward, and the forward channel is sampled exactly one cycle after that event. A lost saved priority or a mis-decoded number shows on the next get readback. A scan that does not stall shows up as `resend_busy_o` dropping while an offer is held.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;
  typedef enum logic [1:0] {
    CFG_SET = 2'd0,
    CFG_OFF = 2'd1,
    CFG_ON  = 2'd2,
    CFG_GET = 2'd3
  } cfg_op_e;

  typedef struct packed {
    logic asserted;
    logic sent;
    logic rejected;
    logic mpend;
  } src_flags_t;

  localparam logic [7:0] PRIO_OFF  = 8'hff;
  localparam logic [7:0] ST_OK     = 8'h00;
  localparam logic [7:0] ST_BADARG = 8'hfd;

  function automatic logic num_in_window(input logic [15:0] n, input int base, input int cnt);
    return (int'(n) >= base) && (int'(n) < base + cnt);
  endfunction
endpackage

// File: rtl/irq_src_slot.sv
module irq_src_slot
  import irq_src_pkg::*;
#(
  parameter bit IS_LEVEL = 1'b0,
  parameter int SRV_W    = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             line_i,
  input  logic             rej_i,
  input  logic             eoi_i,
  input  logic             wr_i,
  input  logic [SRV_W-1:0] wr_srv_i,
  input  logic [7:0]       wr_pri_i,
  input  logic [7:0]       wr_sav_i,
  input  logic             scan_i,
  input  logic             grant_i,
  output logic [SRV_W-1:0] srv_o,
  output logic [7:0]       pri_o,
  output logic [7:0]       sav_o,
  output logic             req_o
);
  logic             line_q, req_q, req_d;
  src_flags_t       flg_q, flg_d;
  logic [SRV_W-1:0] srv_q, srv_d;
  logic [7:0]       pri_q, pri_d, sav_q, sav_d;

  always_comb begin
    flg_d = flg_q;
    req_d = req_q;
    srv_d = srv_q;
    pri_d = pri_q;
    sav_d = sav_q;
    if (grant_i) req_d = 1'b0;
    // line events
    if (IS_LEVEL) begin
      if (line_i != line_q) begin
        flg_d.asserted = line_i;
        if (flg_d.asserted && !flg_d.sent && pri_d != PRIO_OFF) begin
          flg_d.sent = 1'b1;
          req_d      = 1'b1;
        end
      end
    end else if (line_i && !line_q) begin
      if (pri_d == PRIO_OFF) flg_d.mpend = 1'b1;
      else                   req_d       = 1'b1;
    end
    if (rej_i) begin
      flg_d.rejected = 1'b1;
      flg_d.sent     = 1'b0;
    end
    if (eoi_i && IS_LEVEL) flg_d.sent = 1'b0;
    // configuration write
    if (wr_i) begin
      srv_d = wr_srv_i;
      pri_d = wr_pri_i;
      sav_d = wr_sav_i;
      if (req_d && pri_d == PRIO_OFF) begin
        req_d = 1'b0;
        if (IS_LEVEL) flg_d.sent  = 1'b0;
        else          flg_d.mpend = 1'b1;
      end
      if (IS_LEVEL) begin
        if (flg_d.asserted && !flg_d.sent && pri_d != PRIO_OFF) begin
          flg_d.sent = 1'b1;
          req_d      = 1'b1;
        end
      end else if (flg_d.mpend && pri_d != PRIO_OFF) begin
        flg_d.mpend = 1'b0;
        req_d       = 1'b1;
      end
    end
    // resend scan visit
    if (scan_i) begin
      if (IS_LEVEL) begin
        if (flg_d.asserted && !flg_d.sent && pri_d != PRIO_OFF) begin
          flg_d.sent = 1'b1;
          req_d      = 1'b1;
        end
      end else if (flg_d.rejected) begin
        flg_d.rejected = 1'b0;
        if (pri_d != PRIO_OFF) req_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_q <= 1'b0;
      req_q  <= 1'b0;
      flg_q  <= '0;
      srv_q  <= '0;
      pri_q  <= PRIO_OFF;
      sav_q  <= PRIO_OFF;
    end else begin
      line_q <= line_i;
      req_q  <= req_d;
      flg_q  <= flg_d;
      srv_q  <= srv_d;
      pri_q  <= pri_d;
      sav_q  <= sav_d;
    end
  end

  assign srv_o = srv_q;
  assign pri_o = pri_q;
  assign sav_o = sav_q;
  assign req_o = req_q;
endmodule

// File: rtl/irq_src_cfg.sv
module irq_src_cfg
  import irq_src_pkg::*;
#(
  parameter int N     = 8,
  parameter int BASE  = 'h1000,
  parameter int NSRV  = 4,
  parameter int IW    = 3,
  parameter int SRV_W = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    valid_i,
  input  logic [1:0]              op_i,
  input  logic [15:0]             num_i,
  input  logic [15:0]             server_i,
  input  logic [15:0]             prio_i,
  input  logic [N-1:0][SRV_W-1:0] srv_a_i,
  input  logic [N-1:0][7:0]       pri_a_i,
  input  logic [N-1:0][7:0]       sav_a_i,
  output logic [N-1:0]            wr_o,
  output logic [SRV_W-1:0]        wr_srv_o,
  output logic [7:0]              wr_pri_o,
  output logic [7:0]              wr_sav_o,
  output logic                    done_o,
  output logic [7:0]              status_o,
  output logic [SRV_W-1:0]        rd_srv_o,
  output logic [7:0]              rd_pri_o
);
  cfg_op_e          op;
  logic             in_rng, args_ok, ok;
  logic [IW-1:0]    idx;
  logic [SRV_W-1:0] cur_srv;
  logic [7:0]       cur_pri, cur_sav;

  assign op      = cfg_op_e'(op_i);
  assign in_rng  = num_in_window(num_i, BASE, N);
  assign idx     = in_rng ? IW'(num_i - 16'(BASE)) : '0;
  assign cur_srv = srv_a_i[idx];
  assign cur_pri = pri_a_i[idx];
  assign cur_sav = sav_a_i[idx];
  assign args_ok = (op != CFG_SET) || ((int'(server_i) < NSRV) && (prio_i <= 16'h00ff));
  assign ok      = in_rng && args_ok;

  always_comb begin
    wr_o     = '0;
    wr_srv_o = cur_srv;
    wr_pri_o = cur_pri;
    wr_sav_o = cur_sav;
    unique case (op)
      CFG_SET: begin
        wr_srv_o = SRV_W'(server_i);
        wr_pri_o = prio_i[7:0];
        wr_sav_o = prio_i[7:0];
      end
      CFG_OFF: begin
        wr_pri_o = PRIO_OFF;
        wr_sav_o = cur_pri;
      end
      CFG_ON: begin
        wr_pri_o = cur_sav;
        wr_sav_o = cur_sav;
      end
      default: ;
    endcase
    if (valid_i && ok && op != CFG_GET) wr_o[idx] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o   <= 1'b0;
      status_o <= ST_OK;
      rd_srv_o <= '0;
      rd_pri_o <= '0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        status_o <= ok ? ST_OK : ST_BADARG;
        rd_srv_o <= ok ? cur_srv : '0;
        rd_pri_o <= ok ? cur_pri : '0;
      end
    end
  end
endmodule

// File: rtl/irq_src_scan.sv
module irq_src_scan #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stall_i,
  output logic          busy_o,
  output logic [IW-1:0] idx_o,
  output logic [N-1:0]  step_o
);
  logic          busy_q, adv;
  logic [IW-1:0] idx_q;

  assign adv    = busy_q && !stall_i;
  assign busy_o = busy_q;
  assign idx_o  = idx_q;

  always_comb begin
    step_o = '0;
    if (adv) step_o[idx_q] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
      end
    end else if (adv) begin
      if (idx_q == IW'(N - 1)) begin
        busy_q <= 1'b0;
        idx_q  <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/irq_src_arb.sv
module irq_src_arb #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [IW-1:0] sel_o,
  output logic [N-1:0]  grant_o
);
  logic          hold_q;
  logic [IW-1:0] hold_idx_q, pick;

  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) pick = IW'(i);
    end
  end

  assign valid_o = |req_i;
  // keep an unaccepted offer in place
  assign sel_o   = (hold_q && req_i[hold_idx_q]) ? hold_idx_q : pick;

  always_comb begin
    grant_o = '0;
    if (valid_o && ready_i) grant_o[sel_o] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q     <= 1'b0;
      hold_idx_q <= '0;
    end else begin
      hold_q     <= valid_o && !ready_i;
      hold_idx_q <= sel_o;
    end
  end
endmodule

// File: rtl/irq_src_ctl.sv
module irq_src_ctl
  import irq_src_pkg::*;
#(
  parameter int               NUM_SRC     = 8,
  parameter int               NUM_SERVERS = 4,
  parameter int               SRC_BASE    = 'h1000,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = 'h0F,
  localparam int              IDX_W       = $clog2(NUM_SRC),
  localparam int              SRV_W       = $clog2(NUM_SERVERS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_line_i,
  input  logic               cfg_valid_i,
  input  logic [1:0]         cfg_op_i,
  input  logic [15:0]        cfg_num_i,
  input  logic [15:0]        cfg_server_i,
  input  logic [15:0]        cfg_prio_i,
  output logic               cfg_done_o,
  output logic [7:0]         cfg_status_o,
  output logic [SRV_W-1:0]   cfg_rd_server_o,
  output logic [7:0]         cfg_rd_prio_o,
  input  logic               rej_valid_i,
  input  logic [15:0]        rej_num_i,
  input  logic               eoi_valid_i,
  input  logic [15:0]        eoi_num_i,
  input  logic               resend_i,
  output logic               resend_busy_o,
  output logic               fwd_valid_o,
  input  logic               fwd_ready_i,
  output logic [15:0]        fwd_num_o,
  output logic [SRV_W-1:0]   fwd_server_o,
  output logic [7:0]         fwd_prio_o
);
  logic [NUM_SRC-1:0][SRV_W-1:0] srv_a;
  logic [NUM_SRC-1:0][7:0]       pri_a, sav_a;
  logic [NUM_SRC-1:0]            wr, rej_hit, eoi_hit, scan_hit, grant, req;
  logic [SRV_W-1:0]              wr_srv;
  logic [7:0]                    wr_pri, wr_sav;
  logic [IDX_W-1:0]              fwd_sel, scan_idx;
  logic                          scan_stall;

  irq_src_cfg #(
    .N(NUM_SRC), .BASE(SRC_BASE), .NSRV(NUM_SERVERS), .IW(IDX_W), .SRV_W(SRV_W)
  ) u_cfg (
    .clk_i, .rst_ni,
    .valid_i  (cfg_valid_i),
    .op_i     (cfg_op_i),
    .num_i    (cfg_num_i),
    .server_i (cfg_server_i),
    .prio_i   (cfg_prio_i),
    .srv_a_i  (srv_a),
    .pri_a_i  (pri_a),
    .sav_a_i  (sav_a),
    .wr_o     (wr),
    .wr_srv_o (wr_srv),
    .wr_pri_o (wr_pri),
    .wr_sav_o (wr_sav),
    .done_o   (cfg_done_o),
    .status_o (cfg_status_o),
    .rd_srv_o (cfg_rd_server_o),
    .rd_pri_o (cfg_rd_prio_o)
  );

  assign scan_stall = fwd_valid_o && !fwd_ready_i;

  irq_src_scan #(.N(NUM_SRC), .IW(IDX_W)) u_scan (
    .clk_i, .rst_ni,
    .start_i (resend_i),
    .stall_i (scan_stall),
    .busy_o  (resend_busy_o),
    .idx_o   (scan_idx),
    .step_o  (scan_hit)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign rej_hit[i] = rej_valid_i && (rej_num_i == 16'(SRC_BASE + i));
    assign eoi_hit[i] = eoi_valid_i && (eoi_num_i == 16'(SRC_BASE + i));

    irq_src_slot #(.IS_LEVEL(LEVEL_MASK[i]), .SRV_W(SRV_W)) u_slot (
      .clk_i, .rst_ni,
      .line_i   (src_line_i[i]),
      .rej_i    (rej_hit[i]),
      .eoi_i    (eoi_hit[i]),
      .wr_i     (wr[i]),
      .wr_srv_i (wr_srv),
      .wr_pri_i (wr_pri),
      .wr_sav_i (wr_sav),
      .scan_i   (scan_hit[i]),
      .grant_i  (grant[i]),
      .srv_o    (srv_a[i]),
      .pri_o    (pri_a[i]),
      .sav_o    (sav_a[i]),
      .req_o    (req[i])
    );
  end

  irq_src_arb #(.N(NUM_SRC), .IW(IDX_W)) u_arb (
    .clk_i, .rst_ni,
    .req_i   (req),
    .ready_i (fwd_ready_i),
    .valid_o (fwd_valid_o),
    .sel_o   (fwd_sel),
    .grant_o (grant)
  );

  assign fwd_num_o    = 16'(SRC_BASE) + 16'(fwd_sel);
  assign fwd_server_o = srv_a[fwd_sel];
  assign fwd_prio_o   = pri_a[fwd_sel];
endmodule

// File: rtl/irq_src_ctl_chk.sv
module irq_src_ctl_chk #(
  parameter int NUM_SRC  = 8,
  parameter int SRC_BASE = 'h1000,
  parameter int IDX_W    = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cfg_valid_i,
  input logic             cfg_done_o,
  input logic [7:0]       cfg_status_o,
  input logic             fwd_valid_o,
  input logic             fwd_ready_i,
  input logic [15:0]      fwd_num_o,
  input logic [7:0]       fwd_prio_o,
  input logic             resend_busy_o,
  input logic [IDX_W-1:0] scan_idx
);
  AST_FWD_PRIO_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> fwd_prio_o != 8'hff); // R7

  AST_FWD_NUM_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> (int'(fwd_num_o) >= SRC_BASE && int'(fwd_num_o) < SRC_BASE + NUM_SRC)); // R10

  AST_FWD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_valid_o && !fwd_ready_i && !cfg_valid_i) |=> (fwd_valid_o && $stable(fwd_num_o))); // R10

  AST_CFG_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_i |=> cfg_done_o); // R9

  AST_CFG_NO_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_valid_i |=> !cfg_done_o); // R9

  AST_CFG_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_done_o |-> (cfg_status_o == 8'h00 || cfg_status_o == 8'hfd)); // R9

  AST_SCAN_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resend_busy_o && fwd_valid_o && !fwd_ready_i) |=> (resend_busy_o && $stable(scan_idx))); // R11
endmodule

bind irq_src_ctl irq_src_ctl_chk #(
  .NUM_SRC(NUM_SRC), .SRC_BASE(SRC_BASE), .IDX_W(IDX_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_valid_i   (cfg_valid_i),
  .cfg_done_o    (cfg_done_o),
  .cfg_status_o  (cfg_status_o),
  .fwd_valid_o   (fwd_valid_o),
  .fwd_ready_i   (fwd_ready_i),
  .fwd_num_o     (fwd_num_o),
  .fwd_prio_o    (fwd_prio_o),
  .resend_busy_o (resend_busy_o),
  .scan_idx      (scan_idx)
);

// File: tb/irq_src_ctl_tb.sv
module irq_src_ctl_tb;
  localparam int N    = 8;
  localparam int BASE = 'h1000;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [N-1:0] src_line_i = '0;
  logic        cfg_valid_i = 1'b0;
  logic [1:0]  cfg_op_i = '0;
  logic [15:0] cfg_num_i = '0, cfg_server_i = '0, cfg_prio_i = '0;
  logic        cfg_done_o;
  logic [7:0]  cfg_status_o;
  logic [1:0]  cfg_rd_server_o;
  logic [7:0]  cfg_rd_prio_o;
  logic        rej_valid_i = 1'b0, eoi_valid_i = 1'b0, resend_i = 1'b0, fwd_ready_i = 1'b0;
  logic [15:0] rej_num_i = '0, eoi_num_i = '0;
  logic        resend_busy_o, fwd_valid_o;
  logic [15:0] fwd_num_o;
  logic [1:0]  fwd_server_o;
  logic [7:0]  fwd_prio_o;

  int n_chk = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  irq_src_ctl u_dut (.*);

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  function automatic int exp_srv(input int i); return i % 4; endfunction
  function automatic int exp_pri(input int i); return 'h10 + i; endfunction

  task automatic do_cfg(input string rq, input int op, input int num, input int srv,
                        input int pri, input int exp_st);
    @(negedge clk_i);
    cfg_valid_i = 1'b1; cfg_op_i = 2'(op); cfg_num_i = 16'(num);
    cfg_server_i = 16'(srv); cfg_prio_i = 16'(pri);
    @(negedge clk_i);
    cfg_valid_i = 1'b0;
    chk(rq, "cfg_done", cfg_done_o, 1);
    chk(rq, "cfg_status", cfg_status_o, exp_st);
  endtask

  task automatic do_get(input string rq, input int i, input int srv, input int pri);
    do_cfg(rq, 3, BASE + i, 0, 0, 'h00);
    chk(rq, "rd_server", cfg_rd_server_o, srv);
    chk(rq, "rd_prio", cfg_rd_prio_o, pri);
  endtask

  task automatic set_line(input int i, input logic v);
    @(negedge clk_i); src_line_i[i] = v;
    @(negedge clk_i);
  endtask

  task automatic pulse_line(input int i);
    set_line(i, 1'b1);
    set_line(i, 1'b0);
  endtask

  task automatic do_rej(input int num);
    @(negedge clk_i); rej_valid_i = 1'b1; rej_num_i = 16'(num);
    @(negedge clk_i); rej_valid_i = 1'b0;
  endtask

  task automatic do_eoi(input int num);
    @(negedge clk_i); eoi_valid_i = 1'b1; eoi_num_i = 16'(num);
    @(negedge clk_i); eoi_valid_i = 1'b0;
  endtask

  task automatic do_resend();
    @(negedge clk_i); resend_i = 1'b1;
    @(negedge clk_i); resend_i = 1'b0;
  endtask

  task automatic wait_fwd();
    for (int k = 0; k < 40 && !fwd_valid_o; k++) @(negedge clk_i);
  endtask

  task automatic wait_scan();
    for (int k = 0; k < 40 && resend_busy_o; k++) @(negedge clk_i);
  endtask

  task automatic expect_none(input string rq);
    chk(rq, "fwd_valid idle", fwd_valid_o, 0);
  endtask

  task automatic expect_fwd(input string rq, input int i);
    chk(rq, "fwd_valid", fwd_valid_o, 1);
    chk(rq, "fwd_num", fwd_num_o, BASE + i);
    chk(rq, "fwd_server", fwd_server_o, exp_srv(i));
    chk(rq, "fwd_prio", fwd_prio_o, exp_pri(i));
    fwd_ready_i = 1'b1;
    @(negedge clk_i);
    fwd_ready_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk("R1", "fwd_valid", fwd_valid_o, 0);
    chk("R1", "resend_busy", resend_busy_o, 0);
    for (int i = 0; i < N; i++) do_get("R1", i, 0, 'hff);

    // R9 rejected requests
    do_cfg("R9", 3, BASE - 1, 0, 0, 'hfd);
    do_cfg("R9", 3, BASE + N, 0, 0, 'hfd);
    do_cfg("R9", 0, BASE + 2, 4, 'h10, 'hfd);
    do_cfg("R9", 0, BASE + 2, 1, 'h100, 'hfd);
    do_cfg("R9", 1, BASE + N, 0, 0, 'hfd);
    do_get("R9", 2, 0, 'hff);

    // R3 message sources at 0xff become masked-pending
    for (int i = 4; i < N; i++) begin
      pulse_line(i);
      expect_none("R3");
    end

    // R7 set sweep; masked-pending message sources release
    for (int i = 0; i < N; i++) begin
      do_cfg("R7", 0, BASE + i, exp_srv(i), exp_pri(i), 'h00);
      if (i >= 4) expect_fwd("R7", i);
      else expect_none("R7");
    end
    for (int i = 0; i < N; i++) do_get("R7", i, exp_srv(i), exp_pri(i));

    // R3 edge-only behaviour
    set_line(5, 1'b1);
    expect_fwd("R3", 5);
    repeat (3) @(negedge clk_i);
    expect_none("R3");
    set_line(5, 1'b0);
    expect_none("R3");

    // R2 level forward, sent blocks repeats; R6 eoi; R5 resend
    set_line(0, 1'b1);
    expect_fwd("R2", 0);
    repeat (2) @(negedge clk_i);
    expect_none("R2");
    do_eoi(BASE);
    expect_none("R6");
    do_resend();
    wait_fwd();
    expect_fwd("R5", 0);
    wait_scan();
    expect_none("R5");

    // R4 reject then R5 resend
    do_rej(BASE);
    expect_none("R4");
    do_rej(BASE + 5);
    expect_none("R4");
    do_resend();
    wait_fwd();
    expect_fwd("R4", 0);
    wait_fwd();
    expect_fwd("R5", 5);
    wait_scan();
    expect_none("R5");
    do_resend();
    wait_scan();
    expect_none("R5");
    do_eoi(BASE + 5);
    do_resend();
    wait_scan();
    expect_none("R6");
    set_line(0, 1'b0);
    expect_none("R2");

    // R8 off / on with masked-pending
    do_cfg("R8", 1, BASE + 6, 0, 0, 'h00);
    do_get("R8", 6, exp_srv(6), 'hff);
    pulse_line(6);
    expect_none("R8");
    do_cfg("R8", 2, BASE + 6, 0, 0, 'h00);
    expect_fwd("R8", 6);
    do_get("R8", 6, exp_srv(6), exp_pri(6));
    do_cfg("R8", 1, BASE + 7, 0, 0, 'h00);
    do_cfg("R8", 1, BASE + 7, 0, 0, 'h00);
    do_cfg("R8", 2, BASE + 7, 0, 0, 'h00);
    do_get("R8", 7, exp_srv(7), 'hff);
    do_cfg("R8", 0, BASE + 7, exp_srv(7), exp_pri(7), 'h00);
    expect_none("R8");

    // R7 level re-evaluated on enable
    do_cfg("R7", 1, BASE + 1, 0, 0, 'h00);
    set_line(1, 1'b1);
    expect_none("R7");
    do_cfg("R7", 2, BASE + 1, 0, 0, 'h00);
    expect_fwd("R7", 1);
    set_line(1, 1'b0);
    do_eoi(BASE + 1);

    // R7 withdrawal of an unaccepted message forward
    pulse_line(6);
    chk("R7", "pending fwd_valid", fwd_valid_o, 1);
    chk("R7", "pending fwd_num", fwd_num_o, BASE + 6);
    do_cfg("R7", 1, BASE + 6, 0, 0, 'h00);
    expect_none("R7");
    do_cfg("R7", 2, BASE + 6, 0, 0, 'h00);
    expect_fwd("R7", 6);

    // R10 lowest index first, held while not ready
    @(negedge clk_i);
    src_line_i[2] = 1'b1; src_line_i[3] = 1'b1;
    @(negedge clk_i);
    for (int k = 0; k < 5; k++) begin
      chk("R10", "held fwd_num", fwd_num_o, BASE + 2);
      @(negedge clk_i);
    end
    expect_fwd("R10", 2);
    expect_fwd("R10", 3);
    @(negedge clk_i);
    src_line_i[2] = 1'b0; src_line_i[3] = 1'b0;
    do_eoi(BASE + 2);
    do_eoi(BASE + 3);
    expect_none("R10");

    // R11 scan stalls behind an unaccepted forward
    do_rej(BASE + 4);
    do_rej(BASE + 5);
    do_resend();
    wait_fwd();
    chk("R11", "first fwd_num", fwd_num_o, BASE + 4);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk_i);
      chk("R11", "busy while stalled", resend_busy_o, 1);
    end
    chk("R11", "stalled fwd_num", fwd_num_o, BASE + 4);
    expect_fwd("R11", 4);
    wait_fwd();
    expect_fwd("R11", 5);
    wait_scan();
    chk("R11", "scan finished", resend_busy_o, 0);
    expect_none("R11");

    summary();
  end
endmodule